// File: doc/BRIEF.md
# Dynamic Voltage Scaling Reference Ramp Controller

This block produces the digital reference code that sets the output level of a step-down converter. It keeps two 5-bit set-point registers and a select bit that picks one of them as the target. When the target changes, the reference code does not jump to it. It walks toward the target one code at a time, and every move waits one step period. The same step period limits both upward and downward moves. A rate bit chooses between a short period and a long period. Both periods are derived from the system clock through a prescaler.

Raising the enable input starts a soft start. The reference begins at the lowest level and ramps up to the selected set point at the programmed rate. Lowering enable forces the reference back to the lowest level at once. The block gives the current code, the matching level in millivolts, and a busy flag that is high while the reference still differs from the target. Configuration is written through plain strobes, one per field. There is no data stream, so no valid/ready handshake is used and there is no back-pressure.

Top module: `dvs_ref_ramp`

## Requirements
- R1: While `enable` is low, `ref_code` is 00001, `ref_mv` is 800 and `busy` is 0. This follows in the same cycle that `enable` falls, with no clock edge needed.
- R2: The level in millivolts is 800 + 50 × (max(code, 1) − 1), which spans 800 to 2300. A set point of 00000 and a set point of 00001 are the same level: moving between them takes no step time, and both give `ref_code` = 00001.
- R3: The target is set point V1 when the select bit is 1 and set point V2 when the select bit is 0.
- R4: After reset, V1 = 01001, V2 = 00111, select = 1 and the rate bit is 0.
- R5: While the reference is below the target, it rises by exactly one code per step period. The first step comes one full period after the ramp begins.
- R6: The step period is round(2.67 × CLK_PER_US) clock cycles when the rate bit is 0, and round(10.67 × CLK_PER_US) clock cycles when it is 1.
- R7: While the reference is above the target, it falls by exactly one code per step period. It never moves faster than the programmed rate.
- R8: When `enable` rises, the reference starts at 00001 and ramps to the selected set point as described in R5.
- R9: `busy` is 1 exactly while `enable` is high and the reference level differs from the target level. `busy` falls in the cycle the target level is reached.
- R10: If the target changes in the middle of a ramp, the reference continues from its present code toward the new target. It does not restart from the minimum, and the step timer is not cleared.
- R11: Each configuration field loads on a clock edge where its own write strobe is high. Fields whose strobes are low keep their values, and any set of strobes may be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Converter enable; a rising edge starts the soft start |
| v1_we | input | 1 | Write strobe for set point V1 |
| v1_wdata | input | 5 | New value for V1 |
| v2_we | input | 1 | Write strobe for set point V2 |
| v2_wdata | input | 5 | New value for V2 |
| sel_we | input | 1 | Write strobe for the set-point select bit |
| sel_wdata | input | 1 | Select value: 1 picks V1, 0 picks V2 |
| rate_we | input | 1 | Write strobe for the step-rate bit |
| rate_wdata | input | 1 | Rate value: 0 is the short period, 1 is the long period |
| ref_code | output | 5 | Current reference code |
| ref_mv | output | 12 | Current reference level in millivolts |
| busy | output | 1 | High while a ramp is in progress |

## Verification
If the step prescaler holds a wrong count, it shows at the ports on the very next code change. That change comes early or late relative to the step period, so the length of a full ramp is off by a multiple of cycles. If the level register is corrupted, the next cycle shows it as a jump of more than one code, or as `busy` low while `ref_code` differs from the selected set point. If a set-point or select register is corrupted, the ramp goes to the wrong final code, and this is visible as soon as `busy` falls. Ramps of different lengths and directions, at both rates, expose every timing error within one step period of where it happens.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

  // Direction the reference level takes on the next step tick.
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;

  // Converts a time given in hundredths of a microsecond into clock cycles,
  // rounding to the nearest cycle. The result is never below one cycle.
  function automatic int unsigned centi_us_to_cycles(input int unsigned centi_us,
                                                     input int unsigned clk_per_us);
    int unsigned cyc;
    cyc = (centi_us * clk_per_us + 50) / 100;
    if (cyc < 1) cyc = 1;
    return cyc;
  endfunction

endpackage

// File: rtl/dvs_setpoint_bank.sv
// Set-point storage. It holds the two set-point codes, the select bit and the
// rate bit, and it produces the target as a level (codes 0 and 1 merge into level 0).
module dvs_setpoint_bank #(
  parameter int CODE_W = 5,
  parameter int V1_RST = 9,
  parameter int V2_RST = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v1_we,
  input  logic [CODE_W-1:0] v1_wdata,
  input  logic              v2_we,
  input  logic [CODE_W-1:0] v2_wdata,
  input  logic              sel_we,
  input  logic              sel_wdata,
  input  logic              rate_we,
  input  logic              rate_wdata,
  output logic [CODE_W-1:0] tgt_lvl,
  output logic              rate_slow
);

  localparam int NUM_BANKS = 2;

  logic [NUM_BANKS-1:0]             bank_we;
  logic [NUM_BANKS-1:0][CODE_W-1:0] bank_wd;
  logic [NUM_BANKS-1:0][CODE_W-1:0] bank_q;
  logic                             sel_q;
  logic                             rate_q;
  logic [CODE_W-1:0]                tgt_code;

  assign bank_we[0] = v1_we;
  assign bank_we[1] = v2_we;
  assign bank_wd[0] = v1_wdata;
  assign bank_wd[1] = v2_wdata;

  // One register per set-point bank, each with its own reset value.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [CODE_W-1:0] RST_VAL =
      (b == 0) ? CODE_W'(V1_RST) : CODE_W'(V2_RST);
    logic [CODE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= RST_VAL;
      else if (bank_we[b]) q <= bank_wd[b];
    end
    assign bank_q[b] = q;
  end

  // The select bit resets to 1 (V1); the rate bit resets to 0 (short period).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      rate_q <= 1'b0;
    end else begin
      if (sel_we)  sel_q  <= sel_wdata;
      if (rate_we) rate_q <= rate_wdata;
    end
  end

  always_comb begin
    tgt_code = sel_q ? bank_q[0] : bank_q[1];
    if (tgt_code == '0) tgt_lvl = '0;
    else                tgt_lvl = tgt_code - CODE_W'(1);
  end

  assign rate_slow = rate_q;

endmodule

// File: rtl/dvs_step_timer.sv
// Prescaler for the step period. It counts only while a ramp is pending, and
// it pulses tick on the cycle in which the selected period has elapsed.
module dvs_step_timer #(
  parameter int unsigned FAST_CYC = 8,
  parameter int unsigned SLOW_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rate_slow,
  output logic tick
);

  localparam int unsigned MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_CYC - 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             expired;

  assign limit   = rate_slow ? SLOW_LIM : FAST_LIM;
  // The compare uses >= so that switching to the short period mid-ramp
  // steps at once instead of wrapping the counter.
  assign expired = (cnt_q >= limit);
  assign tick    = run && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (expired) cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/dvs_level_tracker.sv
// Holds the present reference level and moves it by one toward the target on
// each tick. The level is held at the minimum while the block is disabled.
module dvs_level_tracker #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LVL_W-1:0] tgt_lvl,
  input  logic             tick,
  output logic [LVL_W-1:0] cur_lvl,
  output logic             moving
);

  import dvs_pkg::*;

  logic [LVL_W-1:0] cur_q;
  step_dir_e        dir;

  always_comb begin
    if (!enable)              dir = DIR_HOLD;
    else if (cur_q < tgt_lvl) dir = DIR_UP;
    else if (cur_q > tgt_lvl) dir = DIR_DOWN;
    else                      dir = DIR_HOLD;
  end

  assign moving  = (dir != DIR_HOLD);
  assign cur_lvl = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (!enable) cur_q <= '0;
    else if (tick) begin
      unique case (dir)
        DIR_UP:   cur_q <= cur_q + LVL_W'(1);
        DIR_DOWN: cur_q <= cur_q - LVL_W'(1);
        default:  cur_q <= cur_q;
      endcase
    end
  end

endmodule

// File: rtl/dvs_code_map.sv
// Maps the internal level to the output code and to a level in millivolts.
// While the block is disabled, both outputs show the minimum at once.
module dvs_code_map #(
  parameter int LVL_W   = 5,
  parameter int MV_W    = 12,
  parameter int MIN_MV  = 800,
  parameter int STEP_MV = 50
) (
  input  logic             enable,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic [LVL_W-1:0] ref_code,
  output logic [MV_W-1:0]  ref_mv
);

  logic [LVL_W-1:0] eff_lvl;

  assign eff_lvl  = enable ? cur_lvl : '0;
  assign ref_code = eff_lvl + LVL_W'(1);
  assign ref_mv   = MV_W'(MIN_MV) + MV_W'(STEP_MV) * MV_W'(eff_lvl);

endmodule

// File: rtl/dvs_ref_ramp.sv
// Top level: set-point bank, step prescaler, level tracker and output map.
module dvs_ref_ramp #(
  parameter int CODE_W        = 5,
  parameter int MV_W          = 12,
  parameter int CLK_PER_US    = 250,
  parameter int FAST_CENTI_US = 267,
  parameter int SLOW_CENTI_US = 1067,
  parameter int V1_RST        = 9,
  parameter int V2_RST        = 7,
  parameter int MIN_MV        = 800,
  parameter int STEP_MV       = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              v1_we,
  input  logic [CODE_W-1:0] v1_wdata,
  input  logic              v2_we,
  input  logic [CODE_W-1:0] v2_wdata,
  input  logic              sel_we,
  input  logic              sel_wdata,
  input  logic              rate_we,
  input  logic              rate_wdata,
  output logic [CODE_W-1:0] ref_code,
  output logic [MV_W-1:0]   ref_mv,
  output logic              busy
);

  localparam int unsigned FAST_CYC =
    dvs_pkg::centi_us_to_cycles(FAST_CENTI_US, CLK_PER_US);
  localparam int unsigned SLOW_CYC =
    dvs_pkg::centi_us_to_cycles(SLOW_CENTI_US, CLK_PER_US);

  logic [CODE_W-1:0] tgt_lvl;
  logic [CODE_W-1:0] cur_lvl;
  logic              rate_slow;
  logic              moving;
  logic              tick;

  dvs_setpoint_bank #(
    .CODE_W (CODE_W),
    .V1_RST (V1_RST),
    .V2_RST (V2_RST)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .v1_we      (v1_we),
    .v1_wdata   (v1_wdata),
    .v2_we      (v2_we),
    .v2_wdata   (v2_wdata),
    .sel_we     (sel_we),
    .sel_wdata  (sel_wdata),
    .rate_we    (rate_we),
    .rate_wdata (rate_wdata),
    .tgt_lvl    (tgt_lvl),
    .rate_slow  (rate_slow)
  );

  dvs_step_timer #(
    .FAST_CYC (FAST_CYC),
    .SLOW_CYC (SLOW_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (moving),
    .rate_slow (rate_slow),
    .tick      (tick)
  );

  dvs_level_tracker #(
    .LVL_W (CODE_W)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .tgt_lvl (tgt_lvl),
    .tick    (tick),
    .cur_lvl (cur_lvl),
    .moving  (moving)
  );

  dvs_code_map #(
    .LVL_W   (CODE_W),
    .MV_W    (MV_W),
    .MIN_MV  (MIN_MV),
    .STEP_MV (STEP_MV)
  ) u_map (
    .enable   (enable),
    .cur_lvl  (cur_lvl),
    .ref_code (ref_code),
    .ref_mv   (ref_mv)
  );

  assign busy = moving;

endmodule

// File: rtl/dvs_ref_ramp_chk.sv
// Property checker, attached to the top module through bind.
module dvs_ref_ramp_chk #(
  parameter int CODE_W        = 5,
  parameter int MV_W          = 12,
  parameter int CLK_PER_US    = 250,
  parameter int FAST_CENTI_US = 267,
  parameter int MIN_MV        = 800,
  parameter int STEP_MV       = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              busy,
  input logic [CODE_W-1:0] ref_code,
  input logic [MV_W-1:0]   ref_mv,
  input logic [CODE_W-1:0] tgt_lvl
);

  localparam int FAST_CYC = int'(dvs_pkg::centi_us_to_cycles(FAST_CENTI_US, CLK_PER_US));
  localparam int MAX_MV   = MIN_MV + STEP_MV * ((1 << CODE_W) - 2);

  logic [CODE_W-1:0] prev_code;
  logic [15:0]       gap;
  logic              chg;

  assign chg = (ref_code != prev_code);

  // Counts the cycles since the last code change, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= CODE_W'(1);
      gap       <= '0;
    end else begin
      prev_code <= ref_code;
      if (chg || !enable)  gap <= '0;
      else if (gap != '1)  gap <= gap + 16'd1;
    end
  end

  a_r1_disabled_floor: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (ref_code == CODE_W'(1) && !busy && ref_mv == MV_W'(MIN_MV)));

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |->
      ({1'b0, ref_code} == {1'b0, $past(ref_code)} ||
       {1'b0, ref_code} == {1'b0, $past(ref_code)} + 1 ||
       {1'b0, ref_code} + 1 == {1'b0, $past(ref_code)}));

  a_r7_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && enable && $past(enable)) |-> (int'(gap) >= FAST_CYC - 1));

  a_r9_idle_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !busy) |-> (ref_code == tgt_lvl + CODE_W'(1)));

  a_r2_mv_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ref_mv) >= MIN_MV && int'(ref_mv) <= MAX_MV &&
     ((int'(ref_mv) - MIN_MV) % STEP_MV) == 0));

endmodule

bind dvs_ref_ramp dvs_ref_ramp_chk #(
  .CODE_W        (CODE_W),
  .MV_W          (MV_W),
  .CLK_PER_US    (CLK_PER_US),
  .FAST_CENTI_US (FAST_CENTI_US),
  .MIN_MV        (MIN_MV),
  .STEP_MV       (STEP_MV)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .busy     (busy),
  .ref_code (ref_code),
  .ref_mv   (ref_mv),
  .tgt_lvl  (tgt_lvl)
);

// File: tb/dvs_ref_ramp_bench.sv
module dvs_ref_ramp_bench;

  localparam int CPU    = 3;
  localparam int P_FAST = 8;   // round(2.67 * 3)
  localparam int P_SLOW = 32;  // round(10.67 * 3)

  typedef struct packed {
    logic       sel;
    logic       rate;
    logic [4:0] v1;
    logic [4:0] v2;
    logic [4:0] exp_code;
    logic [7:0] steps;
  } vec_t;

  // Every entry starts from the final code of the entry before it.
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 5'd20, 5'd7,  5'd20, 8'd13},  // up, short period (starts at 7)
    '{1'b0, 1'b0, 5'd20, 5'd7,  5'd7,  8'd13},  // down, short period
    '{1'b0, 1'b1, 5'd20, 5'd10, 5'd10, 8'd3},   // up, long period
    '{1'b1, 1'b1, 5'd0,  5'd10, 5'd1,  8'd9},   // down to code 0 = level of 1
    '{1'b1, 1'b0, 5'd1,  5'd10, 5'd1,  8'd0},   // 0 -> 1 takes no time
    '{1'b1, 1'b0, 5'd31, 5'd10, 5'd31, 8'd30},  // full climb
    '{1'b0, 1'b0, 5'd31, 5'd31, 5'd31, 8'd0},   // already there
    '{1'b0, 1'b1, 5'd31, 5'd2,  5'd2,  8'd29}   // long descent
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        v1_we = 1'b0, v2_we = 1'b0, sel_we = 1'b0, rate_we = 1'b0;
  logic [4:0]  v1_wdata = '0, v2_wdata = '0;
  logic        sel_wdata = 1'b0, rate_wdata = 1'b0;
  logic [4:0]  ref_code;
  logic [11:0] ref_mv;
  logic        busy;

  int n_cmp = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  dvs_ref_ramp #(.CLK_PER_US(CPU)) u_dvs_ref_ramp (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .v1_we(v1_we), .v1_wdata(v1_wdata), .v2_we(v2_we), .v2_wdata(v2_wdata),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .ref_code(ref_code), .ref_mv(ref_mv), .busy(busy)
  );

  function automatic int exp_mv(input int code);
    return 800 + 50 * ((code < 1 ? 1 : code) - 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge. Strobes are held over one clock edge.
  task automatic write_cfg(input logic w1, input logic [4:0] d1,
                           input logic w2, input logic [4:0] d2,
                           input logic ws, input logic ds,
                           input logic wr, input logic dr);
    v1_we = w1; v1_wdata = d1; v2_we = w2; v2_wdata = d2;
    sel_we = ws; sel_wdata = ds; rate_we = wr; rate_wdata = dr;
    @(posedge clk);
    @(negedge clk);
    v1_we = 1'b0; v2_we = 1'b0; sel_we = 1'b0; rate_we = 1'b0;
  endtask

  // Counts clock edges until busy falls; returns at a negedge.
  task automatic measure(output int cyc);
    cyc = 0;
    while (busy && cyc < 4000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset / disabled state
    check("R1 reset code", int'(ref_code), 1);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset mv", int'(ref_mv), 800);

    // R8 soft start to default V1 (R4), short period by default (R6)
    enable = 1'b1;
    #1;
    check("R8 start code", int'(ref_code), 1);
    check("R9 start busy", int'(busy), 1);
    @(negedge clk);
    measure(cyc);
    cyc = cyc + 1;  // edge before the first negedge wait
    check("R6 soft start cycles", cyc, 8 * P_FAST);
    check("R4 default V1 code", int'(ref_code), 9);
    check("R2 mv at 9", int'(ref_mv), 1200);

    // R4 default V2, R11 select-only write keeps the banks
    write_cfg(1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    measure(cyc);
    check("R4 default V2 cycles", cyc, 2 * P_FAST);
    check("R11 V2 retained", int'(ref_code), 7);

    // Table of ramps (R3 R5 R6 R7 R2)
    for (int i = 0; i < 8; i++) begin
      int per;
      per = VECS[i].rate ? P_SLOW : P_FAST;
      write_cfg(1'b1, VECS[i].v1, 1'b1, VECS[i].v2, 1'b1, VECS[i].sel,
                1'b1, VECS[i].rate);
      measure(cyc);
      check($sformatf("R5 R7 vec %0d cycles", i), cyc, int'(VECS[i].steps) * per);
      check($sformatf("R3 vec %0d code", i), int'(ref_code), int'(VECS[i].exp_code));
      check($sformatf("R2 vec %0d mv", i), int'(ref_mv), exp_mv(int'(VECS[i].exp_code)));
      check($sformatf("R9 vec %0d idle", i), int'(busy), 0);
    end

    // R10 retarget in the middle of a ramp (present code 2)
    write_cfg(1'b1, 5'd11, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    repeat (3 * P_FAST) @(posedge clk);
    @(negedge clk);
    check("R5 mid ramp code", int'(ref_code), 5);
    write_cfg(1'b1, 5'd3, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 no restart code", int'(ref_code), 5);
    check("R10 busy kept", int'(busy), 1);
    measure(cyc);
    check("R10 retarget cycles", cyc, 2 * P_FAST - 1);
    check("R10 final code", int'(ref_code), 3);

    // R1 disable in the middle of a ramp, then R8 soft start again
    write_cfg(1'b1, 5'd20, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    enable = 1'b0;
    #1;
    check("R1 drop code", int'(ref_code), 1);
    check("R1 drop busy", int'(busy), 0);
    check("R1 drop mv", int'(ref_mv), 800);
    @(negedge clk);
    check("R1 held code", int'(ref_code), 1);
    enable = 1'b1;
    #1;
    check("R8 restart code", int'(ref_code), 1);
    check("R9 restart busy", int'(busy), 1);
    repeat (P_FAST - 1) @(posedge clk);
    @(negedge clk);
    check("R5 before first step", int'(ref_code), 1);
    @(negedge clk);
    check("R5 first step", int'(ref_code), 2);
    measure(cyc);
    check("R8 restart cycles", cyc, 18 * P_FAST);
    check("R8 restart final", int'(ref_code), 20);

    finish_run();
  end

endmodule